// File: doc/BRIEF.md
# Privilege-Filtered Cycle Counter

This block is a free-running clock-cycle counter whose increment is gated every cycle by a 32-bit filter register. The filter decides whether a cycle counts. That decision uses the current privilege level (0 to 3) and the security state. Straps give the block's configuration. One strap says whether level 2 exists and another says whether level 3 exists. Filter bits for a level that is not implemented are dropped when written and read back as zero.

The filter can be written in two ways. The first is a direct write strobe. The second is the generic event-type write path, which reaches the filter only when its counter-select value is 31. The counter and the masked filter value are both visible at the outputs at all times. Overflow signalling, event counters and access permission checks are handled elsewhere.

Top module: `cyc_filt_counter`

## Requirements
- R1: After an active-low reset, `count_o` is 0 and `filt_o` is 0.
- R2: While `count_en_i` is low, `count_o` holds its value whatever the other inputs are.
- R3: While `count_en_i` is high and `priv_lvl_i` is 3, every cycle is counted, whatever the filter value.
- R4: At level 1, in the secure state or when `has_lvl3_i` is low, a cycle is counted only when filter bit 31 is 0.
- R5: At level 0, in the secure state or when `has_lvl3_i` is low, a cycle is counted only when filter bit 30 is 0.
- R6: At level 1 in the non-secure state (`nonsec_i`=1) with `has_lvl3_i` high, a cycle is counted only when filter bit 29 equals bit 31.
- R7: At level 0 in the non-secure state with `has_lvl3_i` high, a cycle is counted only when filter bit 28 equals bit 30.
- R8: At level 2, a cycle is counted only when filter bit 27 reads 1. With `has_lvl2_i` low, a write of 1 to bit 27 is dropped, so the bit reads 0.
- R9: Bits 26:0 of `filt_o` always read 0. With `has_lvl3_i` low, bits 29:28 are dropped when written and read 0.
- R10: An event-type write (`evt_we_i`) updates the filter only when `evt_sel_i` equals 31. Any other select leaves `filt_o` unchanged.
- R11: When `filt_we_i` and a qualifying event-type write occur in the same cycle, the value on `filt_wdata_i` is stored.
- R12: A filter write first affects counting in the cycle after its strobe. The cycle of the strobe itself is decided by the old value.
- R13: The counter is `CNT_W` bits wide (64 by default), adds one per qualifying cycle, and wraps from all ones to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low warm reset |
| priv_lvl_i | input | 2 | Current privilege level, 0 to 3 |
| nonsec_i | input | 1 | 1 when executing in the non-secure state |
| has_lvl2_i | input | 1 | Strap: level 2 is implemented |
| has_lvl3_i | input | 1 | Strap: level 3 is implemented |
| count_en_i | input | 1 | Global counting enable |
| filt_we_i | input | 1 | Direct filter write strobe |
| filt_wdata_i | input | 32 | Direct filter write data |
| evt_we_i | input | 1 | Event-type write strobe |
| evt_sel_i | input | 5 | Counter select for the event-type write |
| evt_wdata_i | input | 32 | Event-type write data |
| count_o | output | CNT_W | Cycle count |
| filt_o | output | 32 | Filter readback, masked |

## Verification
The non-secure kernel and user cases are checked with all four combinations of the primary bit and the secondary bit. A design that treats the secondary bit as a plain exclude bit, or that ignores it, counts or skips the wrong two of those four cases. The write path is tested for a write landing in the same cycle that is being counted. It is also tested for an event-type write with the wrong select, and for both write ports firing together. Errors there show up as an off-by-one count, a corrupted filter, or the wrong data winning. Strap masking is checked by writing all ones with a level absent and by counting at level 2. A narrow counter instance is run past its top value to catch a counter that saturates instead of wrapping.

// File: rtl/cyc_filt_pkg.sv
package cyc_filt_pkg;
  localparam int FILT_W   = 32;
  localparam int FLD_W    = 5;
  localparam int FLD_LSB  = FILT_W - FLD_W;  // 27
  // field index within the FLD_W slice
  localparam int F_PRIV   = 4;  // bit 31
  localparam int F_USER   = 3;  // bit 30
  localparam int F_NSKERN = 2;  // bit 29
  localparam int F_NSUSER = 1;  // bit 28
  localparam int F_NSHYP  = 0;  // bit 27

  typedef enum logic [1:0] {
    LVL_USER = 2'd0,
    LVL_KERN = 2'd1,
    LVL_HYP  = 2'd2,
    LVL_MON  = 2'd3
  } priv_e;

  typedef logic [FLD_W-1:0] fld_t;
endpackage

// File: rtl/cyc_filt_reg.sv
module cyc_filt_reg
  import cyc_filt_pkg::*;
#(
  parameter int SEL_W   = 5,
  parameter int IND_SEL = 31
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              has_lvl2_i,
  input  logic              has_lvl3_i,
  input  logic              filt_we_i,
  input  logic [FILT_W-1:0] filt_wdata_i,
  input  logic              evt_we_i,
  input  logic [SEL_W-1:0]  evt_sel_i,
  input  logic [FILT_W-1:0] evt_wdata_i,
  output fld_t              fld_o,
  output logic [FILT_W-1:0] rdata_o
);
  fld_t impl_msk, fld_q, wr_fld;
  logic ind_hit, wr_any;

  always_comb begin
    impl_msk           = '1;
    impl_msk[F_NSKERN] = has_lvl3_i;
    impl_msk[F_NSUSER] = has_lvl3_i;
    impl_msk[F_NSHYP]  = has_lvl2_i;
  end

  assign ind_hit = evt_we_i && (evt_sel_i == SEL_W'(IND_SEL));
  assign wr_any  = filt_we_i || ind_hit;
  // direct port has priority
  assign wr_fld  = filt_we_i ? filt_wdata_i[FILT_W-1:FLD_LSB]
                             : evt_wdata_i[FILT_W-1:FLD_LSB];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     fld_q <= '0;
    else if (wr_any) fld_q <= wr_fld & impl_msk;
  end

  assign fld_o   = fld_q & impl_msk;
  assign rdata_o = {fld_o, {FLD_LSB{1'b0}}};
endmodule

// File: rtl/cyc_filt_qual.sv
module cyc_filt_qual
  import cyc_filt_pkg::*;
(
  input  fld_t        fld_i,
  input  logic [1:0]  priv_lvl_i,
  input  logic        nonsec_i,
  input  logic        has_lvl3_i,
  input  logic        count_en_i,
  output logic        inc_o
);
  logic ns_split, allow;

  assign ns_split = nonsec_i && has_lvl3_i;

  always_comb begin
    unique case (priv_e'(priv_lvl_i))
      LVL_USER: allow = ns_split ? (fld_i[F_NSUSER] == fld_i[F_USER]) : !fld_i[F_USER];
      LVL_KERN: allow = ns_split ? (fld_i[F_NSKERN] == fld_i[F_PRIV]) : !fld_i[F_PRIV];
      LVL_HYP:  allow = fld_i[F_NSHYP];
      default:  allow = 1'b1;
    endcase
  end

  assign inc_o = count_en_i && allow;
endmodule

// File: rtl/cyc_filt_cnt.sv
module cyc_filt_cnt #(
  parameter int CNT_W = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  output logic [CNT_W-1:0] count_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    count_o <= '0;
    else if (inc_i) count_o <= count_o + 1'b1;
  end
endmodule

// File: rtl/cyc_filt_counter.sv
module cyc_filt_counter
  import cyc_filt_pkg::*;
#(
  parameter int CNT_W   = 64,
  parameter int SEL_W   = 5,
  parameter int IND_SEL = 31
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        priv_lvl_i,
  input  logic              nonsec_i,
  input  logic              has_lvl2_i,
  input  logic              has_lvl3_i,
  input  logic              count_en_i,
  input  logic              filt_we_i,
  input  logic [31:0]       filt_wdata_i,
  input  logic              evt_we_i,
  input  logic [SEL_W-1:0]  evt_sel_i,
  input  logic [31:0]       evt_wdata_i,
  output logic [CNT_W-1:0]  count_o,
  output logic [31:0]       filt_o
);
  fld_t fld;
  logic inc;

  cyc_filt_reg #(.SEL_W(SEL_W), .IND_SEL(IND_SEL)) i_reg (
    .clk_i, .rst_ni, .has_lvl2_i, .has_lvl3_i,
    .filt_we_i, .filt_wdata_i, .evt_we_i, .evt_sel_i, .evt_wdata_i,
    .fld_o(fld), .rdata_o(filt_o)
  );

  cyc_filt_qual i_qual (
    .fld_i(fld), .priv_lvl_i, .nonsec_i, .has_lvl3_i, .count_en_i, .inc_o(inc)
  );

  cyc_filt_cnt #(.CNT_W(CNT_W)) i_cnt (
    .clk_i, .rst_ni, .inc_i(inc), .count_o
  );
endmodule

// File: rtl/cyc_filt_checker.sv
module cyc_filt_checker #(
  parameter int CNT_W = 64
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [1:0]       priv_lvl_i,
  input logic             has_lvl2_i,
  input logic             has_lvl3_i,
  input logic             count_en_i,
  input logic             filt_we_i,
  input logic [31:0]      filt_wdata_i,
  input logic [CNT_W-1:0] count_o,
  input logic [31:0]      filt_o
);
  a_r2_hold_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !count_en_i |=> $stable(count_o));

  a_r3_top_level_counts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_en_i && priv_lvl_i == 2'd3) |=> count_o == $past(count_o) + 1'b1);

  a_r13_unit_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (count_o == $past(count_o) + 1'b1) || $stable(count_o));

  a_r9_reserved_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    filt_o[26:0] == '0);

  a_r9_no_lvl3_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !has_lvl3_i |-> filt_o[29:28] == 2'b00);

  a_r8_no_lvl2_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !has_lvl2_i |-> !filt_o[27]);

  a_r11_direct_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    filt_we_i |=> filt_o[31:30] == $past(filt_wdata_i[31:30]));
endmodule

bind cyc_filt_counter cyc_filt_checker #(.CNT_W(CNT_W)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .priv_lvl_i(priv_lvl_i),
  .has_lvl2_i(has_lvl2_i), .has_lvl3_i(has_lvl3_i), .count_en_i(count_en_i),
  .filt_we_i(filt_we_i), .filt_wdata_i(filt_wdata_i),
  .count_o(count_o), .filt_o(filt_o)
);

// File: tb/test_cyc_filt_counter.sv
`timescale 1ns/1ps
module test_cyc_filt_counter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  priv = 2'd3;
  logic        ns = 1'b0, has2 = 1'b1, has3 = 1'b1, en = 1'b0;
  logic        fwe = 1'b0, ewe = 1'b0;
  logic [31:0] fwd = '0, ewd = '0;
  logic [4:0]  esel = '0;
  logic [63:0] count;
  logic [31:0] filt, filt_n;
  logic [3:0]  count_n;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;  // 200 MHz

  cyc_filt_counter i_cyc_filt_counter (
    .clk_i(clk), .rst_ni(rst_n), .priv_lvl_i(priv), .nonsec_i(ns),
    .has_lvl2_i(has2), .has_lvl3_i(has3), .count_en_i(en),
    .filt_we_i(fwe), .filt_wdata_i(fwd), .evt_we_i(ewe), .evt_sel_i(esel),
    .evt_wdata_i(ewd), .count_o(count), .filt_o(filt)
  );

  cyc_filt_counter #(.CNT_W(4)) i_cyc_filt_counter_nar (
    .clk_i(clk), .rst_ni(rst_n), .priv_lvl_i(priv), .nonsec_i(ns),
    .has_lvl2_i(has2), .has_lvl3_i(has3), .count_en_i(en),
    .filt_we_i(fwe), .filt_wdata_i(fwd), .evt_we_i(ewe), .evt_sel_i(esel),
    .evt_wdata_i(ewd), .count_o(count_n), .filt_o(filt_n)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr_filt(input logic [31:0] d);
    @(negedge clk); fwd = d; fwe = 1'b1;
    @(negedge clk); fwe = 1'b0;
  endtask

  // run n cycles in a given state and check the count delta
  task automatic run(input string tag, input logic [1:0] lvl, input logic nsv,
                     input logic env, input int n, input bit counted);
    logic [63:0] c0;
    @(negedge clk); priv = lvl; ns = nsv; en = env;
    c0 = count;
    repeat (n) @(negedge clk);
    chk(tag, count - c0, counted ? 64'(n) : 64'd0);
  endtask

  task automatic t_reset;
    chk("R1 count reset", count, 0);
    chk("R1 filter reset", {32'd0, filt}, 0);
  endtask

  task automatic t_enable_and_top;
    wr_filt(32'hF800_0000);
    run("R2 disabled", 2'd1, 1'b0, 1'b0, 6, 0);
    run("R2 disabled lvl3", 2'd3, 1'b0, 1'b0, 4, 0);
    run("R3 lvl3 all excluded", 2'd3, 1'b1, 1'b1, 7, 1);
  endtask

  task automatic t_secure;
    wr_filt(32'h0000_0000);
    run("R4 secure kern P=0", 2'd1, 1'b0, 1'b1, 5, 1);
    run("R5 secure user U=0", 2'd0, 1'b0, 1'b1, 5, 1);
    wr_filt(32'h8000_0000);
    run("R4 secure kern P=1", 2'd1, 1'b0, 1'b1, 5, 0);
    run("R5 user with P=1", 2'd0, 1'b0, 1'b1, 3, 1);
    wr_filt(32'h4000_0000);
    run("R5 secure user U=1", 2'd0, 1'b0, 1'b1, 5, 0);
    run("R4 kern with U=1", 2'd1, 1'b0, 1'b1, 3, 1);
  endtask

  task automatic t_nonsec;
    // bits {31,29}: counted iff equal
    wr_filt(32'h0000_0000); run("R6 ns kern 00", 2'd1, 1'b1, 1'b1, 4, 1);
    wr_filt(32'h2000_0000); run("R6 ns kern P0 K1", 2'd1, 1'b1, 1'b1, 4, 0);
    wr_filt(32'h8000_0000); run("R6 ns kern P1 K0", 2'd1, 1'b1, 1'b1, 4, 0);
    wr_filt(32'hA000_0000); run("R6 ns kern 11", 2'd1, 1'b1, 1'b1, 4, 1);
    run("R4 secure kern P=1 K=1", 2'd1, 1'b0, 1'b1, 4, 0);
    // bits {30,28}
    wr_filt(32'h1000_0000); run("R7 ns user U0 N1", 2'd0, 1'b1, 1'b1, 4, 0);
    wr_filt(32'h4000_0000); run("R7 ns user U1 N0", 2'd0, 1'b1, 1'b1, 4, 0);
    wr_filt(32'h5000_0000); run("R7 ns user 11", 2'd0, 1'b1, 1'b1, 4, 1);
    wr_filt(32'h0000_0000); run("R7 ns user 00", 2'd0, 1'b1, 1'b1, 4, 1);
  endtask

  task automatic t_lvl2_and_masks;
    run("R8 lvl2 bit27=0", 2'd2, 1'b1, 1'b1, 5, 0);
    wr_filt(32'h0800_0000); run("R8 lvl2 bit27=1", 2'd2, 1'b1, 1'b1, 5, 1);
    wr_filt(32'hFFFF_FFFF);
    chk("R9 reserved masked", {32'd0, filt}, 64'hF800_0000);
    @(negedge clk); has2 = 1'b0; has3 = 1'b0;
    wr_filt(32'hFFFF_FFFF);
    chk("R9 lvl3 absent mask", {32'd0, filt}, 64'hC000_0000);
    run("R8 lvl2 absent", 2'd2, 1'b1, 1'b1, 4, 0);
    wr_filt(32'h2000_0000);
    chk("R9 nsk dropped", {32'd0, filt}, 0);
    run("R4 ns kern no lvl3 uses P", 2'd1, 1'b1, 1'b1, 4, 1);
    @(negedge clk); has2 = 1'b1; has3 = 1'b1;
    chk("R8 dropped bit stays 0", {32'd0, filt}, 0);
  endtask

  task automatic t_indirect;
    @(negedge clk); ewe = 1'b1; esel = 5'd5; ewd = 32'hC000_0000;
    @(negedge clk); ewe = 1'b0;
    chk("R10 other select ignored", {32'd0, filt}, 0);
    @(negedge clk); ewe = 1'b1; esel = 5'd31; ewd = 32'h4800_0000;
    @(negedge clk); ewe = 1'b0;
    chk("R10 select 31 writes", {32'd0, filt}, 64'h4800_0000);
    @(negedge clk); ewe = 1'b1; esel = 5'd31; ewd = 32'h8000_0000;
    fwe = 1'b1; fwd = 32'h1000_0000;
    @(negedge clk); ewe = 1'b0; fwe = 1'b0;
    chk("R11 direct wins", {32'd0, filt}, 64'h1000_0000);
  endtask

  task automatic t_timing;
    logic [63:0] c0;
    wr_filt(32'h0000_0000);
    @(negedge clk); priv = 2'd1; ns = 1'b0; en = 1'b1;
    @(negedge clk); c0 = count; fwd = 32'h8000_0000; fwe = 1'b1;
    @(negedge clk); fwe = 1'b0;
    chk("R12 strobe cycle uses old", count - c0, 1);
    repeat (4) @(negedge clk);
    chk("R12 new value after", count - c0, 1);
  endtask

  task automatic t_wrap;
    logic [3:0] n0;
    @(negedge clk); priv = 2'd3; en = 1'b1; n0 = count_n;
    repeat (21) @(negedge clk);
    chk("R13 narrow wrap", {60'd0, count_n}, {60'd0, 4'(n0 + 4'd5)});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_enable_and_top();
    t_secure();
    t_nonsec();
    t_lvl2_and_masks();
    t_indirect();
    t_timing();
    t_wrap();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule